// File: doc/BRIEF.md
# Multi-Lane Link Packet Transmitter

This block turns application transactions into link packets and spreads the packet bytes over a run-time selected number of byte-wide lanes. Every packet opens with a four-byte header: a data identifier, a 16-bit word count and a header ECC byte. Identifiers from 0x10 upward mark long packets. A long packet is followed by as many payload bytes as the word count gives, then a 16-bit CRC. Identifiers below 0x10 mark short packets, which have only the header and carry 16 bits of user data in the word-count field.

Bytes go out strictly in order, one per active lane per clock, and wrap from the highest active lane back to lane 0 on the next clock. The block keeps the stream position of lane 0 and compares every slot's position with the header, payload and CRC boundaries of the current packet. The CRC bytes therefore land in whatever slots are free after the last payload byte. Slots past the end of the packet carry zero. The application side is a single valid/ready port. A packet is accepted while the block is idle, and payload bytes are then taken lane-aligned on the cycles that carry payload.

Top module: `lnk_pkt_tx`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` is all zero and `app_ready` is 1.
- R2: A packet's first four stream bytes are, in order: data ID, word count bits 7:0, word count bits 15:8, ECC byte.
- R3: The 24-bit header word is ID in bits 7:0 and word count in bits 23:8. ECC bit j is the XOR of the header bits selected by mask j: 0xF12CB7, 0xF2555B, 0x749A6D, 0xB8E38E, 0xDF03F0 and 0xEFFC00 for j = 0 to 5. ECC bits 7:6 are 0.
- R4: The active lane count L is 1 << `lane_sel` (encoding 0, 1, 2, 3 gives 1, 2, 4, 8 lanes), captured when a packet is accepted. Stream byte k of a packet goes out on lane k mod L of output cycle k div L, counting only cycles with `out_valid` = 1. Lanes at or above L carry zero.
- R5: A packet whose ID is below 0x10 is exactly the four header bytes. It has no payload and no CRC.
- R6: A long packet (ID 0x10 or above) carries word-count payload bytes after the header, with word count 0 allowed. Payload byte i sits at stream position 4 + i. It is taken from byte lane (4 + i) mod L of `app_data` in the cycle that carries it.
- R7: A long packet's CRC follows the last payload byte immediately, in the same output cycle when slots remain, low byte first. It is the reflected CRC-16 with polynomial 0x8408, seed 0xFFFF reloaded for every packet, over the payload bytes LSB first, with no final inversion.
- R8: Slots in the packet's final cycle after the last header or CRC byte are zero.
- R9: While idle, `app_ready` is 1. While a packet is in progress, `app_ready` is 1 exactly in cycles whose slots include a payload byte. A payload cycle with `app_valid` = 0 emits nothing (`out_valid` = 0, `out_data` zero) and is offered again on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_sel | input | 2 | Active lane count code, sampled at packet acceptance |
| app_valid | input | 1 | Application offers a packet (idle) or payload bytes (in packet) |
| app_ready | output | 1 | Block accepts a packet or the payload bytes of this cycle |
| app_dtype | input | 8 | Data identifier of the offered packet |
| app_wc | input | 16 | Word count, or user data for a short packet |
| app_data | input | 8*MAX_LANES | Lane-aligned payload bytes |
| out_valid | output | 1 | `out_data` carries a packet cycle |
| out_data | output | 8*MAX_LANES | Lane-parallel output bytes, lane n in bits 8n+7:8n |

## Verification
The two functions that meet in one cycle are the payload-to-CRC handover and the trailing padding. When the word count leaves slots free in the last payload cycle, the CRC bytes and then zero padding must share that cycle with payload bytes. When exactly one slot is free, the CRC low byte sits there and the high byte spills into a cycle of its own. The bench provokes every such alignment by sweeping the word count across all residues of every lane count, with periodic stalls. It rebuilds each packet's byte stream arithmetically and judges header, ECC, payload, CRC and pad bytes separately, along with the per-cycle ready pattern.

// File: rtl/lnk_pkt_pkg.sv
// Shared definitions for the link packet transmitter: header geometry,
// slot classification type, header ECC and byte-wise CRC step.
// Assumes byte-wide lanes and a 16-bit word count.
package lnk_pkt_pkg;

    localparam int HDR_BYTES = 4;
    localparam int CRC_BYTES = 2;
    localparam int WC_W      = 16;
    localparam logic [7:0] LONG_ID_MIN = 8'h10;

    // Role of one lane slot in the current cycle.
    typedef enum logic [2:0] {
        K_ID   = 3'd0,
        K_WCL  = 3'd1,
        K_WCH  = 3'd2,
        K_ECC  = 3'd3,
        K_PAY  = 3'd4,
        K_CRCL = 3'd5,
        K_CRCH = 3'd6,
        K_PAD  = 3'd7
    } slot_t;

    // Six parity masks over the 24-bit header word.
    function automatic logic [7:0] hdr_ecc(input logic [23:0] hw);
        logic [23:0] m [6];
        logic [7:0]  e;
        m[0] = 24'hF12CB7;
        m[1] = 24'hF2555B;
        m[2] = 24'h749A6D;
        m[3] = 24'hB8E38E;
        m[4] = 24'hDF03F0;
        m[5] = 24'hEFFC00;
        e = 8'h00;
        for (int j = 0; j < 6; j++) e[j] = ^(hw & m[j]);
        return e;
    endfunction

    // Reflected CRC-16 (0x8408) advanced by one byte, LSB first.
    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

endpackage

// File: rtl/lnk_hdr_ecc.sv
// Header ECC generator: forms the 24-bit header word from the data ID
// and word count and produces the ECC byte. Purely combinational.
module lnk_hdr_ecc
    import lnk_pkt_pkg::*;
(
    input  logic [7:0]      id,
    input  logic [WC_W-1:0] wc,
    output logic [7:0]      ecc
);
    // Assemble header word and compute parity.
    always_comb ecc = hdr_ecc({wc, id});
endmodule

// File: rtl/lnk_crc_chain.sv
// CRC chain across lane slots: one CRC byte step per lane, each applied
// only when that slot carries a payload byte. Assumes payload slots within
// a cycle are contiguous and in lane order.
module lnk_crc_chain
    import lnk_pkt_pkg::*;
#(
    parameter int MAX_LANES = 8
) (
    input  logic [15:0]            seed,
    input  logic                   pay_en [MAX_LANES],
    input  logic [8*MAX_LANES-1:0] data,
    output logic [15:0]            crc_out
);
    logic [15:0] link [MAX_LANES+1];

    assign link[0] = seed;

    for (genvar s = 0; s < MAX_LANES; s++) begin : g_step
        // Advance the CRC through this slot's byte when it is payload.
        always_comb link[s+1] = pay_en[s] ? crc_byte(link[s], data[8*s +: 8]) : link[s];
    end

    assign crc_out = link[MAX_LANES];
endmodule

// File: rtl/lnk_slot_map.sv
// Slot classifier: given the stream position of lane 0, the active lane
// count and the packet geometry, labels every lane slot as a header byte,
// payload, CRC byte or pad, and flags payload presence and the final cycle.
module lnk_slot_map
    import lnk_pkt_pkg::*;
#(
    parameter int MAX_LANES = 8,
    parameter int CNT_W     = WC_W + 1,
    parameter int LN_W      = $clog2(MAX_LANES) + 1
) (
    input  logic [CNT_W-1:0] pos,
    input  logic [LN_W-1:0]  lanes_n,
    input  logic [WC_W-1:0]  wc,
    input  logic             is_long,
    output slot_t            kind [MAX_LANES],
    output logic             need_data,
    output logic             last
);
    logic [CNT_W-1:0]     pay_end;
    logic [CNT_W-1:0]     total;
    logic [MAX_LANES-1:0] pay_vec;

    // Packet boundaries in stream bytes.
    always_comb begin
        pay_end = CNT_W'(HDR_BYTES) + CNT_W'(wc);
        total   = is_long ? pay_end + CNT_W'(CRC_BYTES) : CNT_W'(HDR_BYTES);
    end

    for (genvar s = 0; s < MAX_LANES; s++) begin : g_slot
        logic [CNT_W-1:0] idx;
        assign idx = pos + CNT_W'(s);
        // Classify this slot by its stream position.
        always_comb begin
            if (LN_W'(s) >= lanes_n || idx >= total) kind[s] = K_PAD;
            else if (idx < CNT_W'(HDR_BYTES))        kind[s] = slot_t'({1'b0, idx[1:0]});
            else if (idx < pay_end)                  kind[s] = K_PAY;
            else if (idx == pay_end)                 kind[s] = K_CRCL;
            else                                     kind[s] = K_CRCH;
        end
        assign pay_vec[s] = (kind[s] == K_PAY);
    end

    // Payload presence and end-of-packet detection.
    always_comb begin
        need_data = |pay_vec;
        last      = (pos + CNT_W'(lanes_n)) >= total;
    end
endmodule

// File: rtl/lnk_pkt_tx.sv
// Multi-lane link packet transmitter top. Accepts a packet (ID + word
// count) while idle, then emits header, payload, CRC and pad bytes striped
// over 1/2/4/8 active byte lanes, one registered output cycle per step.
// Assumes lane_sel is only meaningful at acceptance; payload is supplied
// lane-aligned on cycles where app_ready is high.
module lnk_pkt_tx
    import lnk_pkt_pkg::*;
#(
    parameter int MAX_LANES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             lane_sel,
    input  logic                   app_valid,
    output logic                   app_ready,
    input  logic [7:0]             app_dtype,
    input  logic [WC_W-1:0]        app_wc,
    input  logic [8*MAX_LANES-1:0] app_data,
    output logic                   out_valid,
    output logic [8*MAX_LANES-1:0] out_data
);
    localparam int CNT_W = WC_W + 1;
    localparam int LN_W  = $clog2(MAX_LANES) + 1;

    logic                   busy;
    logic [CNT_W-1:0]       pos;
    logic [LN_W-1:0]        lanes_q;
    logic [LN_W-1:0]        lanes_req;
    logic [7:0]             id_q;
    logic [WC_W-1:0]        wc_q;
    logic [15:0]            crc_q;
    logic [15:0]            crc_end;
    logic [7:0]             ecc;
    logic                   is_long;
    logic                   need_data;
    logic                   last;
    logic                   accept;
    logic                   step;
    slot_t                  kind   [MAX_LANES];
    logic                   pay_en [MAX_LANES];
    logic [8*MAX_LANES-1:0] slot_bytes;

    // Decode requested lane count, clamped to the lanes that exist.
    always_comb begin
        int unsigned req;
        req = 32'd1 << lane_sel;
        lanes_req = (req > MAX_LANES) ? LN_W'(MAX_LANES) : LN_W'(req);
    end

    // Handshake and progress control.
    always_comb begin
        is_long   = (id_q >= LONG_ID_MIN);
        app_ready = !busy || need_data;
        accept    = !busy && app_valid;
        step      = busy && (!need_data || app_valid);
    end

    lnk_hdr_ecc u_ecc (
        .id  (id_q),
        .wc  (wc_q),
        .ecc (ecc)
    );

    lnk_slot_map #(
        .MAX_LANES (MAX_LANES),
        .CNT_W     (CNT_W),
        .LN_W      (LN_W)
    ) u_map (
        .pos       (pos),
        .lanes_n   (lanes_q),
        .wc        (wc_q),
        .is_long   (is_long),
        .kind      (kind),
        .need_data (need_data),
        .last      (last)
    );

    for (genvar s = 0; s < MAX_LANES; s++) begin : g_lane
        assign pay_en[s] = (kind[s] == K_PAY);
        // Select the byte driven on this lane slot.
        always_comb begin
            unique case (kind[s])
                K_ID:    slot_bytes[8*s +: 8] = id_q;
                K_WCL:   slot_bytes[8*s +: 8] = wc_q[7:0];
                K_WCH:   slot_bytes[8*s +: 8] = wc_q[15:8];
                K_ECC:   slot_bytes[8*s +: 8] = ecc;
                K_PAY:   slot_bytes[8*s +: 8] = app_data[8*s +: 8];
                K_CRCL:  slot_bytes[8*s +: 8] = crc_end[7:0];
                K_CRCH:  slot_bytes[8*s +: 8] = crc_end[15:8];
                default: slot_bytes[8*s +: 8] = 8'h00;
            endcase
        end
    end

    lnk_crc_chain #(
        .MAX_LANES (MAX_LANES)
    ) u_crc (
        .seed    (crc_q),
        .pay_en  (pay_en),
        .data    (app_data),
        .crc_out (crc_end)
    );

    // Packet state: capture on acceptance, advance position per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            pos     <= '0;
            lanes_q <= LN_W'(1);
            id_q    <= '0;
            wc_q    <= '0;
            crc_q   <= 16'hFFFF;
        end else if (accept) begin
            busy    <= 1'b1;
            pos     <= '0;
            lanes_q <= lanes_req;
            id_q    <= app_dtype;
            wc_q    <= app_wc;
            crc_q   <= 16'hFFFF;
        end else if (step) begin
            pos   <= pos + CNT_W'(lanes_q);
            crc_q <= crc_end;
            if (last) busy <= 1'b0;
        end
    end

    // Registered lane output; zero on idle and stalled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= step;
            out_data  <= step ? slot_bytes : '0;
        end
    end
endmodule

// File: rtl/lnk_pkt_tx_chk.sv
// Assertion checker for lnk_pkt_tx, bound to every instance. Observes the
// handshake, output bus and packet state registers.
module lnk_pkt_tx_chk #(
    parameter int MAX_LANES = 8,
    parameter int CNT_W     = 17,
    parameter int LN_W      = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   app_valid,
    input logic                   app_ready,
    input logic                   out_valid,
    input logic [8*MAX_LANES-1:0] out_data,
    input logic                   busy,
    input logic [CNT_W-1:0]       pos,
    input logic [LN_W-1:0]        lanes_q,
    input logic [15:0]            crc_q
);
    logic upper_clear;

    // Whether all lanes at or above the active count are zero.
    always_comb begin
        upper_clear = 1'b1;
        for (int s = 0; s < MAX_LANES; s++)
            if (LN_W'(s) >= lanes_q && out_data[8*s +: 8] != 8'h00) upper_clear = 1'b0;
    end

    assert_quiet_when_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_data == '0);

    assert_unused_lanes_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> upper_clear);

    assert_idle_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> app_ready);

    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && app_ready && !app_valid |=> !out_valid && $stable(pos) && busy);

    assert_accept_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && app_valid |=> busy && pos == '0);

    assert_crc_seed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && app_valid |=> crc_q == 16'hFFFF);
endmodule

bind lnk_pkt_tx lnk_pkt_tx_chk #(
    .MAX_LANES (MAX_LANES),
    .CNT_W     (CNT_W),
    .LN_W      (LN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .app_valid (app_valid),
    .app_ready (app_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .busy      (busy),
    .pos       (pos),
    .lanes_q   (lanes_q),
    .crc_q     (crc_q)
);

// File: tb/tb_lnk_pkt_tx.sv
// Sweep bench: every lane count, word counts across all lane residues,
// short packets, periodic payload stalls; streams rebuilt arithmetically.
module tb_lnk_pkt_tx;
    localparam int ML = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    lane_sel = 2'd0;
    logic          app_valid = 1'b0;
    logic          app_ready;
    logic [7:0]    app_dtype = 8'h00;
    logic [15:0]   app_wc = 16'h0000;
    logic [8*ML-1:0] app_data = '0;
    logic          out_valid;
    logic [8*ML-1:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cur_l   = 1;
    int lane_bad = 0;
    int cycles  = 0;
    byte unsigned got[$];
    byte unsigned exp_q[$];

    always #4 clk = ~clk;

    lnk_pkt_tx #(.MAX_LANES(ML)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_sel  (lane_sel),
        .app_valid (app_valid),
        .app_ready (app_ready),
        .app_dtype (app_dtype),
        .app_wc    (app_wc),
        .app_data  (app_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic chk(input string tag, input bit ok, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic byte unsigned pay_byte(input int i, input logic [7:0] id);
        return byte'((i * 37 + id * 5 + 1) & 8'hFF);
    endfunction

    function automatic logic [7:0] ref_ecc(input logic [7:0] id, input logic [15:0] wc);
        logic [23:0] masks [6];
        logic [23:0] hw;
        logic [7:0]  e;
        masks[0] = 24'hF12CB7; masks[1] = 24'hF2555B; masks[2] = 24'h749A6D;
        masks[3] = 24'hB8E38E; masks[4] = 24'hDF03F0; masks[5] = 24'hEFFC00;
        hw = {wc, id};
        e = 8'h00;
        for (int j = 0; j < 6; j++)
            for (int b = 0; b < 24; b++)
                if (masks[j][b]) e[j] = e[j] ^ hw[b];
        return e;
    endfunction

    function automatic logic [15:0] ref_crc(input int n, input logic [7:0] id);
        logic [15:0] c;
        logic [7:0]  d;
        logic        fb;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            d = pay_byte(i, id);
            for (int k = 0; k < 8; k++) begin
                fb = c[0] ^ d[k];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        return c;
    endfunction

    // Compare got[] against exp_q[] over a segment; one check per segment.
    task automatic seg(input string tag, input int start, input int len);
        int bad = -1;
        for (int i = start; i < start + len; i++)
            if (bad < 0 && (i >= got.size() || got[i] != exp_q[i])) bad = i;
        if (bad < 0) chk(tag, 1'b1, 0, 0);
        else chk(tag, 1'b0, (bad < got.size()) ? int'(got[bad]) : -1, int'(exp_q[bad]));
    endtask

    // Monitor: collect active-lane bytes, flag nonzero inactive lanes.
    always @(negedge clk) begin
        if (out_valid) begin
            for (int s = 0; s < ML; s++) begin
                if (s < cur_l) got.push_back(out_data[8*s +: 8]);
                else if (out_data[8*s +: 8] != 8'h00) lane_bad++;
            end
        end
    end

    task automatic run_pkt(input int sel, input logic [7:0] id, input logic [15:0] wc, input int stall_mod);
        int  l = 1 << sel;
        bit  lng = (id >= 8'h10);
        int  tot = lng ? 4 + int'(wc) + 2 : 4;
        int  p = 0;
        int  cyc = 0;
        int  rdy_bad = 0;
        int  stall_bad = 0;
        bit  prev_stall = 1'b0;
        logic [15:0] crc;

        exp_q.delete();
        exp_q.push_back(id);
        exp_q.push_back(wc[7:0]);
        exp_q.push_back(wc[15:8]);
        exp_q.push_back(ref_ecc(id, wc));
        crc = ref_crc(int'(wc), id);
        if (lng) begin
            for (int i = 0; i < int'(wc); i++) exp_q.push_back(pay_byte(i, id));
            exp_q.push_back(crc[7:0]);
            exp_q.push_back(crc[15:8]);
        end
        while (exp_q.size() % l != 0) exp_q.push_back(8'h00);

        @(negedge clk);
        got.delete();
        lane_bad = 0;
        cur_l = l;
        chk("R9 idle ready", app_ready === 1'b1, int'(app_ready), 1);
        lane_sel  = 2'(sel);
        app_dtype = id;
        app_wc    = wc;
        app_valid = 1'b1;
        @(posedge clk);
        while (p < tot) begin
            bit has = 1'b0;
            bit stall;
            @(negedge clk);
            if (prev_stall && out_valid !== 1'b0) stall_bad++;
            for (int s = 0; s < l; s++)
                if (lng && p + s >= 4 && p + s < 4 + int'(wc)) has = 1'b1;
            if (app_ready !== has) rdy_bad++;
            stall = has && stall_mod != 0 && (cyc % stall_mod == 1);
            cyc++;
            app_valid = has && !stall;
            app_data = '0;
            for (int s = 0; s < l; s++)
                if (lng && p + s >= 4 && p + s < 4 + int'(wc))
                    app_data[8*s +: 8] = pay_byte(p + s - 4, id);
            prev_stall = stall;
            @(posedge clk);
            if (!stall) p += l;
        end
        @(negedge clk);
        app_valid = 1'b0;
        app_data = '0;
        @(negedge clk);

        chk($sformatf("R9 ready pattern L=%0d wc=%0d", l, wc), rdy_bad == 0, rdy_bad, 0);
        if (stall_mod != 0)
            chk($sformatf("R9 stall emits nothing wc=%0d", wc), stall_bad == 0, stall_bad, 0);
        chk($sformatf("R4 stream length L=%0d id=%0h wc=%0d", l, id, wc),
            got.size() == exp_q.size(), got.size(), exp_q.size());
        chk($sformatf("R4 inactive lanes zero L=%0d", l), lane_bad == 0, lane_bad, 0);
        seg($sformatf("R2 header order L=%0d id=%0h", l, id), 0, 3);
        seg($sformatf("R3 header ecc id=%0h wc=%0h", id, wc), 3, 1);
        if (lng) begin
            seg($sformatf("R6 payload L=%0d wc=%0d", l, wc), 4, int'(wc));
            seg($sformatf("R7 crc placement L=%0d wc=%0d", l, wc), 4 + int'(wc), 2);
        end else begin
            chk($sformatf("R5 short packet length L=%0d", l),
                got.size() == ((4 + l - 1) / l) * l, got.size(), ((4 + l - 1) / l) * l);
        end
        seg($sformatf("R8 padding zero L=%0d wc=%0d", l, wc), tot, exp_q.size() - tot);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset out_valid", out_valid === 1'b0, int'(out_valid), 0);
        chk("R1 reset out_data", out_data === '0, int'(out_data[31:0]), 0);
        chk("R1 reset app_ready", app_ready === 1'b1, int'(app_ready), 1);

        for (int sel = 0; sel < 4; sel++) begin
            run_pkt(sel, 8'h00, 16'hA55A, 0);
            run_pkt(sel, 8'h0F, 16'h0000, 0);
            run_pkt(sel, 8'h10, 16'd1, 0);
            for (int wc = 0; wc < 18; wc++)
                run_pkt(sel, 8'h2A, 16'(wc), (wc % 2 == 1) ? 3 : 0);
            run_pkt(sel, 8'hFF, 16'd33, 2);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule